// File: doc/BRIEF.md
# Register-Pair Byte Multiplier

This unit watches a stream of instruction bytes for a two-byte multiply instruction. When it sees one, it reads a single 16-bit register pair and multiplies the pair's upper byte by its lower byte, both taken as unsigned values. It then writes the 16-bit product back over the same pair. The multiply runs as shift-and-add, one multiplier bit per cycle.

The register pair file sits outside the unit. The unit drives a 2-bit pair index and reads that entry's contents combinationally. It writes back through a one-cycle write enable. A busy output covers the whole operation, and a done pulse marks the write-back. Condition flags are not touched and have no port.

Top module: `pair_multiplier`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done and pair_we are low.
- R2: A multiply starts only when two bytes are accepted in order: the prefix EDh, then a second byte with bits [7:6]=01 and bits [3:0]=1100. Bits [5:4] of the second byte select the pair: 00=BC (entry 0), 01=DE (entry 1), 10=HL (entry 2), 11=SP (entry 3). A byte is accepted on a rising edge where op_valid is high.
- R3: The written value is the unsigned product of bits [15:8] and bits [7:0] of the selected entry. So FFFFh gives FE01h, any zero byte gives 0000h, and 01h times N gives N.
- R4: The product is written into the selected entry only. The other three entries keep their contents.
- R5: busy is high from the cycle after the second byte is accepted through the write-back cycle. done and pair_we are high in the 9th cycle after the acceptance edge and low in the 8th.
- R6: If the byte after the prefix does not match the pattern, it is dropped and no done is raised. The unit then needs a fresh prefix, so a matching byte that follows without one starts nothing.
- R7: Bytes presented while busy is high are ignored. They start no later multiply and cause no further write.
- R8: A matching second byte with no prefix before it starts nothing.
- R9: done lasts exactly one cycle per multiply and coincides with pair_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Marks op_byte as present this cycle |
| op_byte | input | 8 | Instruction byte |
| pair_sel | output | 2 | Index of the register pair being read or written |
| pair_rdata | input | 16 | Contents of the selected pair, combinational |
| pair_we | output | 1 | Write strobe for the selected pair |
| pair_wdata | output | 16 | Product to be written |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at write-back |

## Verification
The second byte is accepted on the edge the bench calls E0. The operands are loaded on E1, and eight iterations follow on E2 through E9. Done, the write strobe and the product are therefore visible after E9, and the pair file updates on E10. The bench counts edges from E0 and samples one time unit after each edge. It expects done to be low after E8 and high after E9, and it reads the file after E10. For stimulus that must be ignored, the bench watches done and pair_we over a window longer than a full operation. It then compares the whole file against a snapshot taken before the stimulus.

// File: rtl/pair_multiplier.sv
module pair_multiplier (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [7:0]  op_byte,
  output logic [1:0]  pair_sel,
  input  logic [15:0] pair_rdata,
  output logic        pair_we,
  output logic [15:0] pair_wdata,
  output logic        busy,
  output logic        done
);

  localparam logic [7:0] PREFIX = 8'hED;

  typedef enum logic [2:0] {S_IDLE, S_PFX, S_LOAD, S_MUL, S_WB} state_t;

  state_t      state;
  logic [1:0]  sel_q;
  logic [7:0]  a_q, b_q;
  logic [15:0] acc;
  logic [2:0]  cnt;

  wire match = (op_byte[7:6] == 2'b01) && (op_byte[3:0] == 4'b1100);
  wire [15:0] partial = b_q[cnt] ? ({8'h00, a_q} << cnt) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sel_q <= 2'd0;
      a_q   <= 8'd0;
      b_q   <= 8'd0;
      acc   <= 16'd0;
      cnt   <= 3'd0;
    end else begin
      case (state)
        S_IDLE: if (op_valid && op_byte == PREFIX) state <= S_PFX;
        S_PFX: if (op_valid) begin
          if (match) begin
            sel_q <= op_byte[5:4];
            state <= S_LOAD;
          end else begin
            state <= S_IDLE;
          end
        end
        S_LOAD: begin
          a_q   <= pair_rdata[15:8];
          b_q   <= pair_rdata[7:0];
          acc   <= 16'd0;
          cnt   <= 3'd0;
          state <= S_MUL;
        end
        S_MUL: begin
          acc <= acc + partial;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) state <= S_WB;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pair_sel   = sel_q;
  assign pair_wdata = acc;
  assign pair_we    = (state == S_WB);
  assign done       = (state == S_WB);
  assign busy       = (state == S_LOAD) || (state == S_MUL) || (state == S_WB);

  assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pair_wdata == ({8'h00, a_q} * {8'h00, b_q}));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_valid));

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  assert_sel_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(pair_sel));

endmodule

// File: tb/pair_multiplier_bench.sv
`timescale 1ns/1ps
module pair_multiplier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic [1:0]  pair_sel;
  logic [15:0] pair_rdata;
  logic        pair_we;
  logic [15:0] pair_wdata;
  logic        busy;
  logic        done;
  logic [15:0] rf [4];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pair_multiplier u_pair_multiplier (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .pair_sel(pair_sel), .pair_rdata(pair_rdata), .pair_we(pair_we),
    .pair_wdata(pair_wdata), .busy(busy), .done(done));

  assign pair_rdata = rf[pair_sel];
  always @(posedge clk) if (pair_we) rf[pair_sel] <= pair_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    op_valid = 1'b1;
    op_byte  = b;
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  task automatic watch_quiet(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 if (done || pair_we) seen = 1'b1;
    end
    check(req, {31'd0, seen}, 32'd0);
  endtask

  task automatic file_same(input string req, input logic [15:0] snap [4]);
    for (int i = 0; i < 4; i++) check(req, {16'd0, rf[i]}, {16'd0, snap[i]});
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 check("R1 busy in reset", {31'd0, busy}, 0);
    check("R1 done in reset", {31'd0, done}, 0);
    check("R1 we in reset", {31'd0, pair_we}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 busy after reset", {31'd0, busy}, 0);
    check("R1 done after reset", {31'd0, done}, 0);
  endtask

  task automatic t_mul(input logic [1:0] pp, input logic [15:0] val);
    logic [15:0] exp;
    logic [15:0] snap [4];
    @(negedge clk) rf[pp] = val;
    exp = {8'h00, val[15:8]} * {8'h00, val[7:0]};
    for (int i = 0; i < 4; i++) snap[i] = rf[i];
    snap[pp] = exp;
    send_byte(8'hED);
    send_byte({2'b01, pp, 4'b1100});
    @(posedge clk);
    #1 check("R5 busy after accept", {31'd0, busy}, 1);
    repeat (7) @(posedge clk);
    #1 check("R5 done low 8th cycle", {31'd0, done}, 0);
    check("R5 busy 8th cycle", {31'd0, busy}, 1);
    @(posedge clk);
    #1 check("R5 done 9th cycle", {31'd0, done}, 1);
    check("R9 we with done", {31'd0, pair_we}, 1);
    check("R2 pair select", {30'd0, pair_sel}, {30'd0, pp});
    check("R3 product", {16'd0, pair_wdata}, {16'd0, exp});
    @(posedge clk);
    #1 check("R9 done one cycle", {31'd0, done}, 0);
    check("R5 busy ends", {31'd0, busy}, 0);
    file_same("R4 pair file after write", snap);
  endtask

  task automatic t_lone_pattern;
    logic [15:0] snap [4];
    for (int i = 0; i < 4; i++) snap[i] = rf[i];
    send_byte(8'h6C);
    watch_quiet("R8 no start without prefix", 12);
    file_same("R8 file unchanged", snap);
  endtask

  task automatic t_bad_second;
    logic [15:0] snap [4];
    for (int i = 0; i < 4; i++) snap[i] = rf[i];
    send_byte(8'hED);
    send_byte(8'h4D);
    watch_quiet("R6 mismatch no done", 12);
    send_byte(8'h4C);
    watch_quiet("R6 needs fresh prefix", 12);
    send_byte(8'hED);
    send_byte(8'hED);
    send_byte(8'h5C);
    watch_quiet("R6 double prefix drops", 12);
    file_same("R6 file unchanged", snap);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] snap [4];
    @(negedge clk) rf[1] = 16'h0D17;
    for (int i = 0; i < 4; i++) snap[i] = rf[i];
    snap[1] = 16'h012B;
    send_byte(8'hED);
    send_byte(8'h5C);
    send_byte(8'hED);
    send_byte(8'h6C);
    repeat (6) @(posedge clk);
    #1 check("R5 done low with traffic", {31'd0, done}, 0);
    @(posedge clk);
    #1 check("R7 done on time", {31'd0, done}, 1);
    check("R7 product", {16'd0, pair_wdata}, 32'h012B);
    watch_quiet("R7 no second start", 14);
    file_same("R7 file after busy bytes", snap);
  endtask

  initial begin
    rf[0] = 16'h1111; rf[1] = 16'h2222; rf[2] = 16'h3333; rf[3] = 16'h4444;
    t_reset();
    t_lone_pattern();
    t_mul(2'd0, 16'hFFFF);
    t_mul(2'd1, 16'h00AB);
    t_mul(2'd2, 16'h01C3);
    t_mul(2'd3, 16'h3C00);
    t_mul(2'd2, 16'hA55A);
    t_mul(2'd3, 16'hC301);
    t_bad_second();
    t_busy_ignore();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule